// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 18-bit buses, A and B. Each direction has its own storage register. A-to-B storage reads the A bus and can drive the B bus. B-to-A storage reads the B bus and can drive the A bus. Each storage register is steered by its own latch enable and its own direction clock.

- With the latch enable high, the register follows its source bus on every system clock.
- With the latch enable low, the register holds its value.
- With the latch enable low, a rising transition of the direction clock loads the source bus once.

The direction clocks are plain data inputs. A fast system clock samples them to find their rising transitions, so the whole block stays synchronous.

Both ports are modelled as three-state pins with explicit enables. Each bus also has a keeper. A resolved value is published for each bus:

- If the block drives the bus, the bus shows the block's value.
- Otherwise, if the external agent drives the bus, the bus shows the external value.
- Otherwise, the bus shows the last value it carried.

A storage register always reads the resolved bus. As a result, it never sees an undefined level.

Top module: `ubt_xcvr`

## Requirements
- R1: While reset is asserted and after its release, neither port drives its bus. Both storage registers and both keepers read zero, so an undriven bus resolves to 0.
- R2: While the A-to-B latch enable is 1, the A-to-B storage loads the resolved A bus on every system clock edge. With the B port driving, the B bus equals the A bus one system cycle later.
- R3: While the A-to-B latch enable is 0 and the A-to-B clock stays at a constant level (either 0 or 1), the A-to-B storage keeps its value whatever the A bus does.
- R4: While the A-to-B latch enable is 0, a 0-to-1 change of the A-to-B clock loads the A bus into the A-to-B storage exactly once. A 1-to-0 change loads nothing.
- R5: The B port drives the B bus with the A-to-B storage exactly when the active-high input `oe_ab` is 1 and reset is not asserted.
- R6: The B-to-A direction follows R2 to R4 with its own latch enable and clock. The A port drives the A bus exactly when the active-low input `oe_ba_n` is 0 and reset is not asserted.
- R7: When neither the block nor the external agent drives a bus, the resolved bus keeps the last value it carried for as long as it stays undriven. That held value also feeds the storage that reads the bus.
- R8: If the block and the external agent drive the same bus at once, the resolved bus shows the block's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| clk_ab | input | 1 | A-to-B direction clock (sampled) |
| oe_ab | input | 1 | B port drive enable, active high |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| clk_ba | input | 1 | B-to-A direction clock (sampled) |
| oe_ba_n | input | 1 | A port drive enable, active low |
| a_ext_d | input | 18 | Value an external agent puts on bus A |
| a_ext_en | input | 1 | External agent drives bus A |
| b_ext_d | input | 18 | Value an external agent puts on bus B |
| b_ext_en | input | 1 | External agent drives bus B |
| a_drv_d | output | 18 | Value the A port would drive (B-to-A storage) |
| a_drv_en | output | 1 | A port is driving |
| b_drv_d | output | 18 | Value the B port would drive (A-to-B storage) |
| b_drv_en | output | 1 | B port is driving |
| a_bus | output | 18 | Resolved level of bus A |
| b_bus | output | 18 | Resolved level of bus B |

## Verification
The hardest situation to reach is a storage register in transparent mode reading a bus that nobody drives. There, the only source of data is the keeper's memory of an earlier transfer. The stimulus gets there in steps:

1. Drive bus A from the B-to-A direction.
2. Release every driver on bus A.
3. Open the A-to-B latch.

The B bus must then show the value that was last driven onto A. A second delicate case is a capture edge that arrives while the latch is closed: the source bus changes both before and after the edge, on both clock levels. Patterns are walking ones followed by arithmetic mixes, so every bit position is exercised in both directions.

// File: rtl/ubt_pkg.sv
// Package: shared width and storage-mode encoding for the bus transceiver.
// Assumes all users agree on a single data width per bus.
package ubt_pkg;
    localparam int UBT_WIDTH = 18;

    // What a storage element does in the current system cycle.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PASS = 2'd1,
        ST_EDGE = 2'd2
    } store_mode_e;
endpackage

// File: rtl/ubt_edge_det.sv
// Module: detects a 0-to-1 transition of a slow data-rate clock input
// by comparing it with its sample from the previous system cycle.
// Assumes the input is synchronous to clk (or already synchronised).
// The sample register tracks the input even during reset, so a level
// that is high at reset release is never reported as an edge.
module ubt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Keep the previous-cycle sample of the watched input.
    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    // A rise is a high level now after a low level last cycle, outside reset.
    always_comb begin
        rise = rst_n && sig && !sig_q;
    end
endmodule

// File: rtl/ubt_store.sv
// Module: one direction's storage path, a transparent latch and an edge
// register merged into a single register per bit. Latch enable high
// loads every system cycle. Latch enable low loads only on a sampled
// rising edge of the direction clock, and holds otherwise.
// Assumes d is the resolved source bus and never unknown.
module ubt_store
    import ubt_pkg::*;
#(
    parameter int W = UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         dclk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic        rise;
    store_mode_e mode;

    ubt_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (dclk),
        .rise  (rise)
    );

    // Choose between transparent, edge capture and hold for this cycle.
    always_comb begin
        if (le)        mode = ST_PASS;
        else if (rise) mode = ST_EDGE;
        else           mode = ST_HOLD;
    end

    // Identical per-bit channels, each loading unless the mode is hold.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                q[i] <= 1'b0;
            else if (mode != ST_HOLD)  q[i] <= d[i];
        end
    end

    // R2: transparent mode follows the source one cycle later.
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (q == $past(d)));

    // R4: a rising direction clock with the latch closed loads the source.
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && dclk && !$past(dclk)) |=> (q == $past(d)));

    // R3: latch closed and direction clock steady means no change.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && (dclk == $past(dclk))) |=> $stable(q));
endmodule

// File: rtl/ubt_keeper.sv
// Module: resolves one bus from the block's own driver, an external
// driver and a bus-hold keeper. The block's driver has priority, then
// the external driver. With neither, the keeper's last value shows.
// Assumes at most one real driver in normal use; contention is resolved
// deterministically in favour of the block.
module ubt_keeper
    import ubt_pkg::*;
#(
    parameter int W = UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv_en,
    input  logic [W-1:0] drv_d,
    input  logic         ext_en,
    input  logic [W-1:0] ext_d,
    output logic [W-1:0] bus
);
    logic [W-1:0] kq;

    // Resolve the bus level from the drivers and the kept value.
    always_comb begin
        if (drv_en)      bus = drv_d;
        else if (ext_en) bus = ext_d;
        else             bus = kq;
    end

    // Keeper remembers whatever level the bus carried this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) kq <= '0;
        else        kq <= bus;
    end

    // R7: the keeper picks up an external driver's value.
    assert_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !drv_en) |=> (kq == $past(ext_d)));

    // R7: an undriven bus keeps its level.
    assert_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && !drv_en) |=> $stable(kq));
endmodule

// File: rtl/ubt_xcvr.sv
// Module: top of the registered bidirectional transceiver. It holds two
// storage paths (A to B, B to A), two three-state port drivers and two
// bus keepers. Assumes direction clocks and enables are synchronous to
// clk. Ports stay undriven while reset is asserted.
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W = UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le_ab,
    input  logic         clk_ab,
    input  logic         oe_ab,
    input  logic         le_ba,
    input  logic         clk_ba,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_ext_d,
    input  logic         a_ext_en,
    input  logic [W-1:0] b_ext_d,
    input  logic         b_ext_en,
    output logic [W-1:0] a_drv_d,
    output logic         a_drv_en,
    output logic [W-1:0] b_drv_d,
    output logic         b_drv_en,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus
);
    // Port drive enables, gated off during reset.
    always_comb begin
        b_drv_en = oe_ab && rst_n;
        a_drv_en = !oe_ba_n && rst_n;
    end

    ubt_store #(.W(W)) u_store_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le_ab),
        .dclk  (clk_ab),
        .d     (a_bus),
        .q     (b_drv_d)
    );

    ubt_store #(.W(W)) u_store_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le_ba),
        .dclk  (clk_ba),
        .d     (b_bus),
        .q     (a_drv_d)
    );

    ubt_keeper #(.W(W)) u_keep_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .drv_en (a_drv_en),
        .drv_d  (a_drv_d),
        .ext_en (a_ext_en),
        .ext_d  (a_ext_d),
        .bus    (a_bus)
    );

    ubt_keeper #(.W(W)) u_keep_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .drv_en (b_drv_en),
        .drv_d  (b_drv_d),
        .ext_en (b_ext_en),
        .ext_d  (b_ext_d),
        .bus    (b_bus)
    );

    // R5, R8: with the B port enabled, bus B carries the A-to-B storage.
    assert_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ab |-> (b_bus == b_drv_d));

    // R6: with the active-low A enable asserted, bus A carries B-to-A storage.
    assert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ba_n |-> (a_bus == a_drv_d));

    // R1: in reset neither port drives.
    always_comb begin
        if (!rst_n) assert_reset_R1: assert (!a_drv_en && !b_drv_en);
    end
endmodule

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
    import ubt_pkg::*;
    localparam int W = UBT_WIDTH;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         le_ab = 1'b0, clk_ab = 1'b0, oe_ab = 1'b0;
    logic         le_ba = 1'b0, clk_ba = 1'b0, oe_ba_n = 1'b1;
    logic [W-1:0] a_ext_d = '0, b_ext_d = '0;
    logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
    logic [W-1:0] a_drv_d, b_drv_d, a_bus, b_bus;
    logic         a_drv_en, b_drv_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ubt_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .le_ab(le_ab), .clk_ab(clk_ab), .oe_ab(oe_ab),
        .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n),
        .a_ext_d(a_ext_d), .a_ext_en(a_ext_en),
        .b_ext_d(b_ext_d), .b_ext_en(b_ext_en),
        .a_drv_d(a_drv_d), .a_drv_en(a_drv_en),
        .b_drv_d(b_drv_d), .b_drv_en(b_drv_en),
        .a_bus(a_bus), .b_bus(b_bus)
    );

    // Walking ones first, then arithmetic mixes.
    function automatic logic [W-1:0] pat(int k);
        if (k < W) return W'(1) << k;
        return W'((k * 32'h0001_9E37) ^ (k << 11) ^ 32'h0000_02A5);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        @(negedge clk);
        oe_ab = 1'b1;
        oe_ba_n = 1'b0;
        step(); step();
        // R1: no port drives in reset
        chk("R1 drive in reset", W'({a_drv_en, b_drv_en}), '0);
        oe_ab = 1'b0;
        oe_ba_n = 1'b1;
        rst_n = 1'b1;
        step();
        chk("R1 a_bus after reset", a_bus, '0);
        chk("R1 b_bus after reset", b_bus, '0);
        chk("R1 b storage after reset", b_drv_d, '0);
        chk("R1 a storage after reset", a_drv_d, '0);

        // R2: transparent A to B
        a_ext_en = 1'b1;
        oe_ab = 1'b1;
        le_ab = 1'b1;
        for (int k = 0; k < 40; k++) begin
            a_ext_d = pat(k);
            step();
            chk("R2 transparent", b_bus, pat(k));
        end
        chk("R5 b driving", W'(b_drv_en), W'(1));
        held = pat(39);

        // R3: closed latch, clock low then high, source changes
        le_ab = 1'b0;
        for (int k = 0; k < 8; k++) begin
            a_ext_d = pat(k + 50);
            step();
            chk("R3 hold clk low", b_bus, held);
        end

        // R4: captures on rises, not on falls
        for (int k = 0; k < 24; k++) begin
            a_ext_d = pat(k + 70);
            clk_ab = 1'b1;
            step();
            chk("R4 rising capture", b_bus, pat(k + 70));
            a_ext_d = ~pat(k + 70);
            step();
            chk("R3 hold clk high", b_bus, pat(k + 70));
            clk_ab = 1'b0;
            step();
            chk("R4 no capture on fall", b_bus, pat(k + 70));
        end
        held = pat(93);

        // R5: release B port, then R7 keeper on B
        oe_ab = 1'b0;
        step();
        chk("R5 b released", W'(b_drv_en), '0);
        chk("R7 b keeps driven value", b_bus, held);
        b_ext_en = 1'b1;
        b_ext_d = pat(5) ^ pat(100);
        step();
        chk("R5 external on b", b_bus, pat(5) ^ pat(100));
        b_ext_en = 1'b0;
        b_ext_d = '0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 b keeper after release", b_bus, pat(5) ^ pat(100));
        end

        // R8: contention on B resolves to the block
        b_ext_en = 1'b1;
        b_ext_d = ~held;
        oe_ab = 1'b1;
        step();
        chk("R8 contention", b_bus, held);
        b_ext_en = 1'b0;
        oe_ab = 1'b0;

        // R6: B to A, transparent, hold, edge
        a_ext_en = 1'b0;
        b_ext_en = 1'b1;
        oe_ba_n = 1'b0;
        le_ba = 1'b1;
        for (int k = 0; k < 30; k++) begin
            b_ext_d = pat(k + 120);
            step();
            chk("R6 transparent", a_bus, pat(k + 120));
        end
        chk("R6 a driving", W'(a_drv_en), W'(1));
        le_ba = 1'b0;
        for (int k = 0; k < 10; k++) begin
            b_ext_d = pat(k + 200);
            clk_ba = 1'b1;
            step();
            chk("R6 rising capture", a_bus, pat(k + 200));
            b_ext_d = ~pat(k + 200);
            clk_ba = 1'b0;
            step();
            chk("R6 hold", a_bus, pat(k + 200));
        end
        held = pat(209);
        oe_ba_n = 1'b1;
        b_ext_en = 1'b0;
        step();
        chk("R6 a released", W'(a_drv_en), '0);
        chk("R7 a keeps driven value", a_bus, held);

        // R7: transparent A to B fed only by A's keeper
        le_ab = 1'b1;
        oe_ab = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 storage from keeper", b_bus, held);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule